// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block is a synthesizable stand-in for one Ethernet transceiver's management register set. A host reaches it through a single 32-bit management frame register. Each write to that register starts one operation: either a read or a write of a numbered PHY register. A read places the selected register's value in the low half of the frame register. Every operation produces a one-cycle completion pulse, which a controller can latch as its management-done interrupt.

The model holds five state registers: basic control, basic status, advertisement, interrupt source and interrupt mask. It also returns fixed identity, link-partner ability and expansion words. A link-status input is compared against a registered copy of itself. Each rising or falling transition updates the link bits in status and sets the matching interrupt-source bits once. Reading the interrupt-source register returns its contents and clears it in the same access.

Writing the control register is masked, may trigger a soft reset of the whole model, and completes auto-negotiation at once when the restart bit is written. Numbers outside the single device's 32-register space, and numbers with no register behind them, read as zero and ignore writes.

Top module: `phy_mgmt_regs`

## Requirements
- R1: The frame word is decoded as follows. Bit 29 set selects a read and bit 29 clear selects a write. Bits 27:18 hold the register number. Bits 15:0 hold the write data. On the clock edge that takes a frame write, the frame register stores the written word, with bits 31:16 kept as written. For a read, bits 15:0 are replaced by the selected register's value, which is visible from the following cycle.
- R2: `mgmt_done` is high for exactly one cycle, in the cycle after each frame write, and never at any other time.
- R3: After reset, the registers hold these values: control 0x3000, status 0x7809, advertisement 0x01E1, interrupt source 0 and interrupt mask 0. The frame register reads 0 and `mgmt_done` is low.
- R4: Some registers read fixed values: register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001.
- R5: A write to register 0 with bit 15 clear stores the data ANDed with 0x7980. If bit 12 of that data is set, status bit 5 (auto-negotiation complete) is also set.
- R6: A write to register 0 with bit 15 set restores every R3 register value and then applies the current link level. With the link up, status gains 0x0024 and interrupt source becomes 0x00C0. With the link down, interrupt source becomes 0x0010.
- R7: A write to register 4 stores (data AND 0x2D7F) OR 0x0080.
- R8: A read of register 29 returns the interrupt source and clears it. A link transition in the same cycle still leaves its interrupt bits set afterwards.
- R9: Register 30 stores the low 8 bits of written data, and reads return them zero-extended.
- R10: A rising link input sets status bits 2 and 5 and interrupt-source bits 7 and 6. A falling link input clears status bits 2 and 5 and sets interrupt-source bit 4. Each transition acts exactly once, however long the new level is held.
- R11: Register numbers above 31 are ignored and are not aliased onto low numbers. So are registers 1, 7 to 16, 17, 18, 27, 31 and every other number not listed above. All of them read 0, except status, which reads its own value, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_we | input | 1 | Write strobe for the management frame register |
| frame_wdata | input | 32 | Frame word: operation, register number, data |
| link_up | input | 1 | Current link status level |
| frame_rdata | output | 32 | Frame register contents, holding the read result in bits 15:0 |
| mgmt_done | output | 1 | One-cycle pulse when an operation completes |

## Verification
The bench builds the block with its default parameters. The register-number field is 10 bits wide with its lowest bit at 18, and the operation bit is bit 29. With the field wider than the 5-bit register index, the bench can issue numbers such as 32, 34, 0x3FD and 0x3FE. These would alias onto control, identity, interrupt-source and mask registers if the range check were missing. Fixing the identity and partner words at their default values gives the constant-register checks exact expected words. The bench also drives a link transition in the same cycle as an interrupt-source read, so that the clear-versus-set priority can be observed.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int DATA_W = 16;
  localparam int IDX_W  = 5;
  localparam int INT_W  = 8;

  // Register indices inside the single device's space
  localparam logic [IDX_W-1:0] IDX_CTRL    = 5'd0;
  localparam logic [IDX_W-1:0] IDX_STAT    = 5'd1;
  localparam logic [IDX_W-1:0] IDX_ID_HI   = 5'd2;
  localparam logic [IDX_W-1:0] IDX_ID_LO   = 5'd3;
  localparam logic [IDX_W-1:0] IDX_ADV     = 5'd4;
  localparam logic [IDX_W-1:0] IDX_PARTNER = 5'd5;
  localparam logic [IDX_W-1:0] IDX_EXPAN   = 5'd6;
  localparam logic [IDX_W-1:0] IDX_INT_SRC = 5'd29;
  localparam logic [IDX_W-1:0] IDX_INT_MSK = 5'd30;

  // Field masks and bit positions
  localparam logic [DATA_W-1:0] CTRL_KEEP    = 16'h7980;
  localparam int                CTRL_SRST_B  = 15;
  localparam int                CTRL_ANRST_B = 12;
  localparam logic [DATA_W-1:0] ADV_KEEP     = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE    = 16'h0080;
  localparam logic [DATA_W-1:0] STAT_AN_DONE = 16'h0020;
  localparam logic [DATA_W-1:0] STAT_LINKSET = 16'h0024;
  localparam logic [INT_W-1:0]  INT_ON_UP    = 8'hC0;
  localparam logic [INT_W-1:0]  INT_ON_DOWN  = 8'h10;

  typedef struct packed {
    logic              is_read;
    logic              in_range;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata;
  } mgmt_req_t;

  typedef enum logic [1:0] {
    LINK_STEADY = 2'd0,
    LINK_ROSE   = 2'd1,
    LINK_FELL   = 2'd2
  } link_evt_e;

endpackage

// File: rtl/phy_frame_decode.sv
module phy_frame_decode
  import phy_mgmt_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int OP_BIT  = 29,
  parameter int NUM_LSB = 18,
  parameter int NUM_W   = 10
) (
  input  logic [FRAME_W-1:0]        frame,
  output mgmt_req_t                 req,
  output logic [FRAME_W-DATA_W-1:0] upper
);

  localparam int NUM_MSB = NUM_LSB + NUM_W - 1;

  logic [NUM_W-1:0] num;
  logic             hi_clear;

  assign num   = frame[NUM_MSB:NUM_LSB];
  assign upper = frame[FRAME_W-1:DATA_W];

  // Register numbers wider than the index are only valid when the extra bits are zero
  generate
    if (NUM_W > IDX_W) begin : g_wide_num
      assign hi_clear = (num[NUM_W-1:IDX_W] == '0);
    end else begin : g_exact_num
      assign hi_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    req.is_read  = frame[OP_BIT];
    req.in_range = hi_clear;
    req.idx      = num[IDX_W-1:0];
    req.wdata    = frame[DATA_W-1:0];
  end

endmodule

// File: rtl/phy_link_edge.sv
module phy_link_edge
  import phy_mgmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      link_in,
  output link_evt_e evt
);

  logic link_q;
  logic link_d;

  always_comb begin
    link_d = link_in;
    if (link_in && !link_q) begin
      evt = LINK_ROSE;
    end else if (!link_in && link_q) begin
      evt = LINK_FELL;
    end else begin
      evt = LINK_STEADY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
    end else begin
      link_q <= link_d;
    end
  end

  // A transition is reported in one cycle only
  p_edge_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == LINK_ROSE) |=> (evt != LINK_ROSE));

  p_fall_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == LINK_FELL) |=> (evt != LINK_FELL));

endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_mgmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_HI    = 16'h0007,
  parameter logic [DATA_W-1:0] ID_LO    = 16'hC0D1,
  parameter logic [DATA_W-1:0] PARTNER  = 16'h0F71,
  parameter logic [DATA_W-1:0] EXPAN    = 16'h0001,
  parameter logic [DATA_W-1:0] CTRL_RST = 16'h3000,
  parameter logic [DATA_W-1:0] STAT_RST = 16'h7809,
  parameter logic [DATA_W-1:0] ADV_RST  = 16'h01E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  mgmt_req_t         req,
  input  logic              link_lvl,
  input  link_evt_e         link_evt,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - INT_W;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] stat_q, stat_d;
  logic [DATA_W-1:0] adv_q, adv_d;
  logic [INT_W-1:0]  isrc_q, isrc_d;
  logic [INT_W-1:0]  imsk_q, imsk_d;
  logic              ctrl_en, stat_en, adv_en, isrc_en, imsk_en;

  logic wr_hit, rd_hit, soft_rst, ctrl_wr, isrc_rd;
  logic [INT_W-1:0] evt_bits;

  // Operation decode
  always_comb begin
    wr_hit   = req_valid && !req.is_read && req.in_range;
    rd_hit   = req_valid &&  req.is_read && req.in_range;
    soft_rst = wr_hit && (req.idx == IDX_CTRL) && req.wdata[CTRL_SRST_B];
    ctrl_wr  = wr_hit && (req.idx == IDX_CTRL) && !req.wdata[CTRL_SRST_B];
    isrc_rd  = rd_hit && (req.idx == IDX_INT_SRC);
  end

  // Interrupt bits contributed by a link transition
  always_comb begin
    unique case (link_evt)
      LINK_ROSE: evt_bits = INT_ON_UP;
      LINK_FELL: evt_bits = INT_ON_DOWN;
      default:   evt_bits = '0;
    endcase
  end

  // Next state
  always_comb begin
    ctrl_en = ctrl_wr || soft_rst;
    ctrl_d  = soft_rst ? CTRL_RST : (req.wdata & CTRL_KEEP);

    adv_en  = (wr_hit && (req.idx == IDX_ADV)) || soft_rst;
    adv_d   = soft_rst ? ADV_RST : ((req.wdata & ADV_KEEP) | ADV_FORCE);

    imsk_en = (wr_hit && (req.idx == IDX_INT_MSK)) || soft_rst;
    imsk_d  = soft_rst ? '0 : req.wdata[INT_W-1:0];

    stat_en = soft_rst || ctrl_wr || (link_evt != LINK_STEADY);
    stat_d  = soft_rst ? STAT_RST : stat_q;
    if (ctrl_wr && req.wdata[CTRL_ANRST_B]) begin
      stat_d = stat_d | STAT_AN_DONE;
    end
    if (soft_rst) begin
      if (link_lvl) begin
        stat_d = stat_d | STAT_LINKSET;
      end else begin
        stat_d = stat_d & ~STAT_LINKSET;
      end
    end else if (link_evt == LINK_ROSE) begin
      stat_d = stat_d | STAT_LINKSET;
    end else if (link_evt == LINK_FELL) begin
      stat_d = stat_d & ~STAT_LINKSET;
    end

    isrc_en = soft_rst || isrc_rd || (link_evt != LINK_STEADY);
    if (soft_rst) begin
      isrc_d = link_lvl ? INT_ON_UP : INT_ON_DOWN;
    end else begin
      isrc_d = (isrc_rd ? '0 : isrc_q) | evt_bits;
    end
  end

  // Read multiplexer, valued before any clear-on-read takes effect
  always_comb begin
    rd_data = '0;
    if (req.in_range) begin
      unique case (req.idx)
        IDX_CTRL:    rd_data = ctrl_q;
        IDX_STAT:    rd_data = stat_q;
        IDX_ID_HI:   rd_data = ID_HI;
        IDX_ID_LO:   rd_data = ID_LO;
        IDX_ADV:     rd_data = adv_q;
        IDX_PARTNER: rd_data = PARTNER;
        IDX_EXPAN:   rd_data = EXPAN;
        IDX_INT_SRC: rd_data = {{PAD_W{1'b0}}, isrc_q};
        IDX_INT_MSK: rd_data = {{PAD_W{1'b0}}, imsk_q};
        default:     rd_data = '0;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
      adv_q  <= ADV_RST;
      isrc_q <= '0;
      imsk_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (stat_en) stat_q <= stat_d;
      if (adv_en)  adv_q  <= adv_d;
      if (isrc_en) isrc_q <= isrc_d;
      if (imsk_en) imsk_q <= imsk_d;
    end
  end

  p_ctrl_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == ($past(req.wdata) & CTRL_KEEP)));

  p_soft_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == CTRL_RST) && (adv_q == ADV_RST) && (imsk_q == '0));

  p_isrc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (isrc_rd && !soft_rst && (link_evt == LINK_STEADY)) |=> (isrc_q == '0));

  p_link_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (link_evt == LINK_ROSE) |=> (stat_q[2] && stat_q[5] && isrc_q[7] && isrc_q[6]));

  p_link_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (link_evt == LINK_FELL) |=> (!stat_q[2] && !stat_q[5] && isrc_q[4]));

  p_far_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req.is_read && !req.in_range && (link_evt == LINK_STEADY))
      |=> ($stable(ctrl_q) && $stable(adv_q) && $stable(imsk_q) && $stable(stat_q)));

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int                FRAME_W  = 32,
  parameter int                OP_BIT   = 29,
  parameter int                NUM_LSB  = 18,
  parameter int                NUM_W    = 10,
  parameter logic [DATA_W-1:0] ID_HI    = 16'h0007,
  parameter logic [DATA_W-1:0] ID_LO    = 16'hC0D1,
  parameter logic [DATA_W-1:0] PARTNER  = 16'h0F71,
  parameter logic [DATA_W-1:0] EXPAN    = 16'h0001,
  parameter logic [DATA_W-1:0] CTRL_RST = 16'h3000,
  parameter logic [DATA_W-1:0] STAT_RST = 16'h7809,
  parameter logic [DATA_W-1:0] ADV_RST  = 16'h01E1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_we,
  input  logic [FRAME_W-1:0] frame_wdata,
  input  logic               link_up,
  output logic [FRAME_W-1:0] frame_rdata,
  output logic               mgmt_done
);

  localparam int UP_W = FRAME_W - DATA_W;

  mgmt_req_t         req;
  logic [UP_W-1:0]   upper;
  link_evt_e         link_evt;
  logic [DATA_W-1:0] rd_data;

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               frame_en;
  logic               done_q, done_d;

  phy_frame_decode #(
    .FRAME_W (FRAME_W),
    .OP_BIT  (OP_BIT),
    .NUM_LSB (NUM_LSB),
    .NUM_W   (NUM_W)
  ) u_decode (
    .frame (frame_wdata),
    .req   (req),
    .upper (upper)
  );

  phy_link_edge u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_in (link_up),
    .evt     (link_evt)
  );

  phy_reg_bank #(
    .ID_HI    (ID_HI),
    .ID_LO    (ID_LO),
    .PARTNER  (PARTNER),
    .EXPAN    (EXPAN),
    .CTRL_RST (CTRL_RST),
    .STAT_RST (STAT_RST),
    .ADV_RST  (ADV_RST)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (frame_we),
    .req       (req),
    .link_lvl  (link_up),
    .link_evt  (link_evt),
    .rd_data   (rd_data)
  );

  // Frame register next state: a read lands its result in the low half
  always_comb begin
    frame_en = frame_we;
    frame_d  = {upper, (req.is_read ? rd_data : req.wdata)};
    done_d   = frame_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (frame_en) frame_q <= frame_d;
      done_q <= done_d;
    end
  end

  assign frame_rdata = frame_q;
  assign mgmt_done   = done_q;

  p_upper_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_we |=> (frame_rdata[FRAME_W-1:DATA_W] == $past(frame_wdata[FRAME_W-1:DATA_W])));

  p_write_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_we && !frame_wdata[OP_BIT]) |=> (frame_rdata == $past(frame_wdata)));

  p_done_after_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_we |=> mgmt_done);

  p_no_stray_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_we |=> !mgmt_done);

endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;

  logic        clk;
  logic        rst_n;
  logic        frame_we;
  logic [31:0] frame_wdata;
  logic        link_up;
  logic [31:0] frame_rdata;
  logic        mgmt_done;

  int n_cmp   = 0;
  int n_bad   = 0;
  int n_ops   = 0;
  int n_dones = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  phy_mgmt_regs uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_we    (frame_we),
    .frame_wdata (frame_wdata),
    .link_up     (link_up),
    .frame_rdata (frame_rdata),
    .mgmt_done   (mgmt_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver: issue one management operation and queue the expected frame word
  task automatic mgmt(input bit rd, input int num, input logic [15:0] data,
                      input logic [15:0] exp_rd, input string tag,
                      input logic [1:0] extra = 2'b00,
                      input bit chg_link = 1'b0, input bit new_link = 1'b0);
    logic [31:0] w;
    w        = '0;
    w[31:30] = extra;
    w[29]    = rd;
    w[27:18] = num[9:0];
    w[17:16] = extra;
    w[15:0]  = data;
    @(negedge clk);
    frame_wdata = w;
    frame_we    = 1'b1;
    if (chg_link) link_up = new_link;
    exp_q.push_back({w[31:16], (rd ? exp_rd : data)});
    tag_q.push_back(tag);
    n_ops++;
    @(negedge clk);
    frame_we = 1'b0;
  endtask

  task automatic set_link(input bit v);
    @(negedge clk);
    link_up = v;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compare each completion against the queued expectation
  always @(negedge clk) begin
    if (rst_n && mgmt_done) begin
      n_dones++;
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R2: actual unexpected done expected none, frame 0x%08h", frame_rdata);
      end else begin
        check(tag_q.pop_front(), frame_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R2: actual watchdog expired expected run to complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    frame_we    = 1'b0;
    frame_wdata = '0;
    link_up     = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 frame after reset", frame_rdata, 32'h0);
    check("R3 done after reset", {31'h0, mgmt_done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 reset values
    mgmt(1, 0,  16'h0, 16'h3000, "R3 control");
    mgmt(1, 1,  16'h0, 16'h7809, "R3 status");
    mgmt(1, 4,  16'h0, 16'h01E1, "R3 advertisement");
    mgmt(1, 29, 16'h0, 16'h0000, "R3 interrupt source");
    mgmt(1, 30, 16'h0, 16'h0000, "R3 interrupt mask");

    // R4 constants
    mgmt(1, 2, 16'h0, 16'h0007, "R4 id high");
    mgmt(1, 3, 16'h0, 16'hC0D1, "R4 id low");
    mgmt(1, 5, 16'h0, 16'h0F71, "R4 partner");
    mgmt(1, 6, 16'h0, 16'h0001, "R4 expansion");

    // R10 link rise, R8 clear on read
    set_link(1'b1);
    mgmt(1, 1,  16'h0, 16'h782D, "R10 status after rise");
    mgmt(1, 29, 16'h0, 16'h00C0, "R10 source after rise");
    mgmt(1, 29, 16'h0, 16'h0000, "R8 source cleared");
    repeat (4) @(negedge clk);
    mgmt(1, 29, 16'h0, 16'h0000, "R10 held level sets once");

    // R10 link fall
    set_link(1'b0);
    mgmt(1, 29, 16'h0, 16'h0010, "R10 source after fall");
    mgmt(1, 1,  16'h0, 16'h7809, "R10 status after fall");

    // R5 control writes
    mgmt(0, 0, 16'h1000, 16'h0, "R5 write restart");
    mgmt(1, 0, 16'h0, 16'h1000, "R5 control masked");
    mgmt(1, 1, 16'h0, 16'h7829, "R5 autoneg complete");
    mgmt(0, 0, 16'h6FFF, 16'h0, "R5 write no restart");
    mgmt(1, 0, 16'h0, 16'h6980, "R5 control masked 2");
    mgmt(1, 1, 16'h0, 16'h7829, "R5 status kept");

    // R7 advertisement
    mgmt(0, 4, 16'hFFFF, 16'h0, "R7 write all ones");
    mgmt(1, 4, 16'h0, 16'h2DFF, "R7 all ones");
    mgmt(0, 4, 16'h0000, 16'h0, "R7 write zero");
    mgmt(1, 4, 16'h0, 16'h0080, "R7 forced bit");

    // R9 mask
    mgmt(0, 30, 16'hABCD, 16'h0, "R9 write mask");
    mgmt(1, 30, 16'h0, 16'h00CD, "R9 mask low byte");

    // R11 ignored registers and numbers
    mgmt(0, 1,  16'hFFFF, 16'h0, "R11 write status");
    mgmt(1, 1,  16'h0, 16'h7829, "R11 status unchanged");
    mgmt(0, 17, 16'hFFFF, 16'h0, "R11 write 17");
    mgmt(1, 17, 16'h0, 16'h0000, "R11 read 17");
    mgmt(1, 27, 16'h0, 16'h0000, "R11 read 27");
    mgmt(1, 31, 16'h0, 16'h0000, "R11 read 31");
    mgmt(1, 7,  16'h0, 16'h0000, "R11 read 7");
    mgmt(0, 32, 16'h8000, 16'h0, "R11 far reset ignored");
    mgmt(1, 0,  16'h0, 16'h6980, "R11 control unchanged");
    mgmt(0, 'h3FE, 16'h0011, 16'h0, "R11 far mask write");
    mgmt(1, 30, 16'h0, 16'h00CD, "R11 mask unchanged");
    mgmt(1, 'h3FD, 16'h0, 16'h0000, "R11 far source read");
    mgmt(1, 34, 16'h0, 16'h0000, "R11 far id read");

    // R6 soft reset with link up
    set_link(1'b1);
    mgmt(1, 29, 16'h0, 16'h00C0, "R10 second rise");
    mgmt(0, 0, 16'h8000, 16'h0, "R6 soft reset");
    mgmt(1, 0,  16'h0, 16'h3000, "R6 control");
    mgmt(1, 4,  16'h0, 16'h01E1, "R6 advertisement");
    mgmt(1, 30, 16'h0, 16'h0000, "R6 mask");
    mgmt(1, 1,  16'h0, 16'h782D, "R6 status link up");
    mgmt(1, 29, 16'h0, 16'h00C0, "R6 source link up");
    mgmt(1, 29, 16'h0, 16'h0000, "R8 cleared after reset");

    // R8 clear and link fall in the same cycle
    mgmt(1, 29, 16'h0, 16'h0000, "R8 read during fall", 2'b00, 1'b1, 1'b0);
    mgmt(1, 29, 16'h0, 16'h0010, "R8 fall survives clear");
    mgmt(1, 1,  16'h0, 16'h7809, "R10 status after fall 2");

    // R1 upper bits kept
    mgmt(1, 2,  16'h5555, 16'h0007, "R1 read keeps upper", 2'b11);
    mgmt(0, 17, 16'h1234, 16'h0, "R1 write echoes word", 2'b10);

    repeat (4) @(negedge clk);
    check("R2 one done per operation", n_dones, n_ops);
    check("R2 queue drained", exp_q.size(), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule